// File: doc/BRIEF.md
# Outbound Address Window Decoder

This block sits between a CPU-side bus and a PCI host bridge and decides where each address goes. The top of the 32-bit space, from 0xF0000000 upward, is cut into thirty-two 8 MB chunks. A CPU address in chunk i is sent to PCI memory space only when the bridge's forwarding mode is on and the window-enable bit for that chunk is set. Everything else is kept local. A forwarded address reaches PCI memory unchanged.

Two software-written registers hold the state. The control register carries a two-bit mode field; forwarding is on only when that field holds binary 01. The window-enable register has one bit per chunk. The lowest chunk is reserved for firmware and the highest for the bridge itself, so those two bits are cleared on every write and can never be forwarded. The block also decodes the reverse direction. It sorts addresses raised by PCI bus masters into system RAM, which is everything below 0xF0800000, or PCI memory, which is the 31 chunks above that.

All decoding is combinational. Register updates apply to requests from the clock cycle after the write.

Top module: `pci_outbound_window`

## Requirements
- R1: After reset, both registers read 0 and no CPU address is forwarded.
- R2: The window-enable register sits at offset 0x14. A write stores the data ANDed with 0x7FFFFFFE, so bits 0 and 31 always read 0. Reading it returns the stored value.
- R3: The control register sits at offset 0x10. It stores all 32 written bits and reads back exactly as written.
- R4: Forwarding is on only when control bits [8:7] equal 2'b01. With any other value (00, 10 or 11), no address is forwarded.
- R5: For chunk i = 1..30, where the address is 0xF0000000 + i*8 MB up to the end of that chunk and i = addr[27:23], the address is forwarded exactly when forwarding is on and enable bit i is set.
- R6: Addresses below 0xF0000000 are never forwarded. Addresses in chunk 0 (0xF0000000..0xF07FFFFF) and chunk 31 (0xFF800000..0xFFFFFFFF) are never forwarded either.
- R7: When an address is forwarded, the PCI address output equals the CPU address bit for bit. When it is local, that output is 0.
- R8: A bus-master address below 0xF0800000 is flagged as system RAM. Any other bus-master address is flagged as PCI memory. Exactly one of the two flags is high.
- R9: A register write changes routing and readback from the next clock cycle on, not in the same cycle. Writes to any offset other than 0x10 or 0x14 change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 8 | Register read byte offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| cpu_addr | input | 32 | CPU-side request address |
| cpu_to_pci | output | 1 | High when the request is forwarded to PCI memory |
| pci_addr | output | 32 | Forwarded address, or 0 when local |
| bm_addr | input | 32 | Bus-master request address |
| bm_to_ram | output | 1 | Bus-master address targets system RAM |
| bm_to_pci | output | 1 | Bus-master address targets PCI memory |

## Verification
Several properties are checked on every cycle. Addresses below the window, and addresses in the two reserved chunks, are never routed out. A forwarded address passes through unaltered. Any mode value other than 01 blocks forwarding. The two reserved enable bits never read back set. A register write is visible in the following cycle. The bus-master split at 0xF0800000 is also checked continuously. Some behaviour can only be shown by the bench's scenarios: which particular chunk an enable bit opens, the exact boundaries between neighbouring chunks, full-width readback of the control register, and the fact that a write has no effect in the cycle it is issued.

// File: rtl/pci_outbound_window.sv
module pci_outbound_window #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned REG_AW     = 8,
  parameter int unsigned CHUNK_BITS = 23,
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned REGION_TAG = 15,
  parameter int unsigned MODE_LSB   = 7,
  parameter logic [1:0]  MODE_ON    = 2'b01,
  parameter logic [7:0]  CTRL_OFS   = 8'h10,
  parameter logic [7:0]  WIN_OFS    = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_to_pci,
  output logic [ADDR_W-1:0] pci_addr,
  input  logic [ADDR_W-1:0] bm_addr,
  output logic              bm_to_ram,
  output logic              bm_to_pci
);
  localparam int unsigned NCHUNK  = 1 << IDX_W;
  localparam int unsigned TAG_LSB = CHUNK_BITS + IDX_W;
  localparam int unsigned TAG_W   = ADDR_W - TAG_LSB;
  localparam logic [ADDR_W-1:0] REGION_BASE = ADDR_W'(REGION_TAG) << TAG_LSB;
  localparam logic [ADDR_W-1:0] BM_RAM_TOP  = REGION_BASE + (ADDR_W'(1) << CHUNK_BITS);

  logic [NCHUNK-1:0] win_mask;
  always_comb begin
    win_mask = '1;
    win_mask[0] = 1'b0;
    win_mask[NCHUNK-1] = 1'b0;
  end

  logic [DATA_W-1:0] ctrl_q;
  logic [NCHUNK-1:0] win_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      win_q  <= '0;
    end else if (reg_we) begin
      if (reg_waddr == REG_AW'(CTRL_OFS)) ctrl_q <= reg_wdata;
      if (reg_waddr == REG_AW'(WIN_OFS))  win_q  <= reg_wdata[NCHUNK-1:0] & win_mask;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_raddr == REG_AW'(CTRL_OFS)) reg_rdata = ctrl_q;
    else if (reg_raddr == REG_AW'(WIN_OFS)) reg_rdata = DATA_W'(win_q);
  end

  logic             fwd_on;
  logic             in_region;
  logic [IDX_W-1:0] chunk;

  assign fwd_on     = ctrl_q[MODE_LSB +: 2] == MODE_ON;
  assign in_region  = cpu_addr[ADDR_W-1:TAG_LSB] == TAG_W'(REGION_TAG);
  assign chunk      = cpu_addr[CHUNK_BITS +: IDX_W];
  assign cpu_to_pci = fwd_on && in_region && win_q[chunk];
  assign pci_addr   = cpu_to_pci ? cpu_addr : '0;

  assign bm_to_ram  = bm_addr < BM_RAM_TOP;
  assign bm_to_pci  = !bm_to_ram;
endmodule

module pci_outbound_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [7:0]  reg_waddr,
  input logic [31:0] reg_wdata,
  input logic [7:0]  reg_raddr,
  input logic [31:0] reg_rdata,
  input logic [31:0] cpu_addr,
  input logic        cpu_to_pci,
  input logic [31:0] pci_addr,
  input logic [31:0] bm_addr,
  input logic        bm_to_ram,
  input logic        bm_to_pci,
  input logic [31:0] ctrl_q
);
  p_low_local_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr < 32'hF000_0000) |-> !cpu_to_pci);
  p_edge_chunks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[31:28] == 4'hF && (cpu_addr[27:23] == 5'd0 || cpu_addr[27:23] == 5'd31)) |-> !cpu_to_pci);
  p_mode_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[8:7] != 2'b01) |-> !cpu_to_pci);
  p_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_to_pci |-> (pci_addr == cpu_addr));
  p_win_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_raddr == 8'h14) |-> (reg_rdata[0] == 1'b0 && reg_rdata[31] == 1'b0));
  p_win_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_waddr == 8'h14 && reg_raddr == 8'h14) |=>
      (reg_rdata == ($past(reg_wdata) & 32'h7FFF_FFFE)) || (reg_raddr != 8'h14));
  p_bm_split_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_addr >= 32'hF080_0000) |-> (bm_to_pci && !bm_to_ram));
  p_bm_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_addr < 32'hF080_0000) |-> (bm_to_ram && !bm_to_pci));
endmodule

bind pci_outbound_window pci_outbound_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
  .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
  .cpu_addr(cpu_addr), .cpu_to_pci(cpu_to_pci), .pci_addr(pci_addr),
  .bm_addr(bm_addr), .bm_to_ram(bm_to_ram), .bm_to_pci(bm_to_pci),
  .ctrl_q(ctrl_q)
);

// File: tb/tb_pci_outbound_window.sv
module tb_pci_outbound_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [7:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic [31:0] cpu_addr = '0;
  logic        cpu_to_pci;
  logic [31:0] pci_addr;
  logic [31:0] bm_addr = '0;
  logic        bm_to_ram;
  logic        bm_to_pci;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pci_outbound_window dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .cpu_addr(cpu_addr), .cpu_to_pci(cpu_to_pci), .pci_addr(pci_addr),
    .bm_addr(bm_addr), .bm_to_ram(bm_to_ram), .bm_to_pci(bm_to_pci)
  );

  // {ctrl, enable write data, cpu address, expected forward}
  localparam int NV = 12;
  localparam logic [96:0] VEC [NV] = '{
    {32'h0000_0080, 32'h0000_0002, 32'hF080_0000, 1'b1},
    {32'h0000_0080, 32'h0000_0002, 32'hF0FF_FFFF, 1'b1},
    {32'h0000_0080, 32'h0000_0002, 32'hF100_0000, 1'b0},
    {32'h0000_0180, 32'h0000_0002, 32'hF080_0000, 1'b0},
    {32'h0000_0100, 32'h0000_0002, 32'hF080_0000, 1'b0},
    {32'h0000_0080, 32'hFFFF_FFFF, 32'hF000_0000, 1'b0},
    {32'h0000_0080, 32'hFFFF_FFFF, 32'hFF80_0000, 1'b0},
    {32'h0000_0080, 32'hFFFF_FFFF, 32'hFF7F_FFFC, 1'b1},
    {32'h0000_0080, 32'hFFFF_FFFF, 32'hEFFF_FFFF, 1'b0},
    {32'hFFFF_FEFF, 32'h4000_0000, 32'hFF00_0000, 1'b1},
    {32'h0000_0080, 32'h0001_0000, 32'hF812_3456, 1'b1},
    {32'h0000_0080, 32'h0001_0000, 32'h7800_0000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_raddr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h10, v); chk("R1 ctrl reset", v, 32'h0);
    rd(8'h14, v); chk("R1 win reset", v, 32'h0);
    cpu_addr = 32'hF080_0000; #1 chk("R1 no forward", {31'b0, cpu_to_pci}, 32'h0);

    // R4 R5 R6 R7 table
    for (int i = 0; i < NV; i++) begin
      logic [31:0] c, e, a; logic x;
      {c, e, a, x} = VEC[i];
      wr(8'h10, c);
      wr(8'h14, e);
      cpu_addr = a;
      #1;
      chk("R5 route", {31'b0, cpu_to_pci}, {31'b0, x});
      chk("R7 pci addr", pci_addr, x ? a : 32'h0);
    end

    // R3 full-width control readback
    wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h10, v); chk("R3 ctrl readback", v, 32'hDEAD_BEEF);
    // R2 masked enable readback
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, v); chk("R2 win mask", v, 32'h7FFF_FFFE);
    wr(8'h14, 32'h8000_0001);
    rd(8'h14, v); chk("R2 win reserved bits", v, 32'h0);

    // R9 other offset ignored
    wr(8'h10, 32'h0000_0080);
    wr(8'h14, 32'h0000_0004);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R9 ctrl untouched", v, 32'h0000_0080);
    rd(8'h14, v); chk("R9 win untouched", v, 32'h0000_0004);

    // R9 effect only from next cycle
    cpu_addr = 32'hF180_0000; // chunk 3
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = 8'h14; reg_wdata = 32'h0000_0008;
    #1 chk("R9 same cycle", {31'b0, cpu_to_pci}, 32'h0);
    @(negedge clk);
    reg_we = 1'b0;
    #1 chk("R9 next cycle", {31'b0, cpu_to_pci}, 32'h1);

    // R8 bus-master split
    bm_addr = 32'h0000_0000; #1 chk("R8 low ram", {30'b0, bm_to_ram, bm_to_pci}, 32'h2);
    bm_addr = 32'hF07F_FFFF; #1 chk("R8 top ram", {30'b0, bm_to_ram, bm_to_pci}, 32'h2);
    bm_addr = 32'hF080_0000; #1 chk("R8 first pci", {30'b0, bm_to_ram, bm_to_pci}, 32'h1);
    bm_addr = 32'hFFFF_FFFF; #1 chk("R8 last pci", {30'b0, bm_to_ram, bm_to_pci}, 32'h1);

    // R1 reset clears state again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(8'h14, v); chk("R1 win after reset", v, 32'h0);
    #1 chk("R1 route after reset", {31'b0, cpu_to_pci}, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule